// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block sits between a processor's bus port and its execute stage. It runs a fetcher that walks code addresses in order and loads the bytes it reads into a small circular byte queue. Meanwhile the execute stage takes opcode bytes off the head of the queue, one or two per cycle. Because of this, instruction fetch overlaps execution, and the execute stage only waits when the queue cannot supply the bytes it asks for.

A taken jump or any other redirect drives the flush input together with a new code address. The queue is then emptied, and fetching starts again from that address. When the execute stage needs a data operand, it raises an operand request. The operand read gets the next free bus slot ahead of any further prefetch, and prefetching picks up where it left off once the operand read is done.

A parameter picks one of two variants. The 16-bit bus variant has a six-byte queue and can bring in two bytes per transfer. The 8-bit bus variant has a four-byte queue and fetches one byte per transfer.

Top module: `pq_prefetch_queue`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the queue is empty (`q_level` = 0) and `mem_req` is low. The first fetch goes to `RESET_ADDR`. The fetch address then grows by the number of bytes each fetch writes, so bytes come out of the queue in ascending address order.
- R2: Bytes come out of the queue in the order they were written. `pop_data[7:0]` is the head byte and `pop_data[15:8]` is the byte after it. A pop and a fetch write may happen in the same cycle.
- R3: With `BUS16` = 1 the queue holds 6 bytes. With `BUS16` = 0 it holds 4 bytes.
- R4: When `flush` is high at a clock edge, `q_level` is 0 after that edge. The next bytes written come from `flush_addr` and the addresses that follow it, and pops stall until those bytes arrive.
- R5: When the queue is full and no flush or operand request is present, no new transfer starts. Fetching resumes only after a pop makes room.
- R6: An operand request wins the bus whenever the bus is free. Bus requests are granted in this order: operand read first, then prefetch. The operand read drives `opr_addr` on `mem_addr`, and `opr_done` pulses in the cycle the data is accepted. After that, prefetch continues from the address where it stopped.
- R7: If a pop asks for more bytes than the queue holds, `pop_stall` is high and no byte is removed.
- R8: If a fetch is still in flight when a flush arrives, the fetch completes on the bus, but its data is thrown away and never appears at `pop_data`.
- R9: In the 16-bit variant, a fetch is a two-byte transfer (`mem_wide` = 1) only when the address is even and at least two entries are free. Otherwise it is a one-byte transfer, taking lane `[15:8]` for an odd address and lane `[7:0]` for an even one. The 8-bit variant uses only one-byte transfers on lane `[7:0]`.
- R10: Once `mem_req` rises, it stays high with `mem_addr` unchanged until a cycle in which `mem_ready` is high.
- R11: `pop_cnt` values 0, 1 and 2 request that many bytes. The value 3 is handled like 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | Bus transfer request |
| mem_addr | output | ADDR_W | Byte address of the transfer |
| mem_wide | output | 1 | Current fetch moves two bytes |
| mem_rdata | input | BUS_W (16 or 8) | Read data, valid with mem_ready |
| mem_ready | input | 1 | Transfer completes this cycle |
| pop_cnt | input | 2 | Bytes requested by the execute side |
| pop_data | output | 16 | Head byte in [7:0], next byte in [15:8] |
| pop_stall | output | 1 | Requested bytes not available |
| q_level | output | CNT_W | Bytes held in the queue |
| flush | input | 1 | Discard queue and redirect fetch |
| flush_addr | input | ADDR_W | New fetch address |
| opr_req | input | 1 | Operand read request, held until opr_done |
| opr_addr | input | ADDR_W | Operand address |
| opr_done | output | 1 | Operand read accepted this cycle |
| opr_data | output | BUS_W (16 or 8) | Operand read data |

## Verification
The hardest case to reach is a flush that lands while a prefetch is waiting on the bus. Hitting that window needs control over the bus latency. The bench therefore holds `mem_ready` low, pops just enough bytes to start a fetch, and then pulses `flush` while the transfer is still pending. After releasing the bus, it checks that the first byte popped belongs to the new address. The operand-priority case is set up the same way: the operand request arrives while a fetch is stalled on the bus, which forces an arbitration once that fetch completes.

// File: rtl/pq_pkg.sv
package pq_pkg;

  typedef enum logic [1:0] {
    BUS_IDLE  = 2'd0,
    BUS_FETCH = 2'd1,
    BUS_OPER  = 2'd2
  } bus_st_e;

  // Queue depth follows bus width: wider bus, deeper queue.
  function automatic int depth_for(input bit bus16);
    return bus16 ? 6 : 4;
  endfunction

endpackage

// File: rtl/pq_byte_fifo.sv
module pq_byte_fifo #(
  parameter int DEPTH = 6,
  parameter int CNT_W = 3,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [1:0]       wr_n,
  input  logic [15:0]      wr_data,
  input  logic [1:0]       rd_n,
  output logic [15:0]      rd_data,
  output logic [CNT_W-1:0] count
);

  logic [7:0]       slot_q [DEPTH];
  logic [PTR_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic [PTR_W-1:0] head1, tail1;
  logic [DEPTH-1:0] we_lo, we_hi;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p, input int n);
    int s;
    s = int'(p) + n;
    if (s >= DEPTH) s = s - DEPTH;
    return PTR_W'(s);
  endfunction

  always_comb begin
    head1   = step(head_q, 1);
    tail1   = step(tail_q, 1);
    head_d  = clr ? '0 : step(head_q, int'(rd_n));
    tail_d  = clr ? '0 : step(tail_q, int'(wr_n));
    count_d = clr ? '0 : count_q + CNT_W'(wr_n) - CNT_W'(rd_n);
    for (int i = 0; i < DEPTH; i++) begin
      we_lo[i] = (wr_n != 2'd0) && (tail_q == PTR_W'(i));
      we_hi[i] = (wr_n == 2'd2) && (tail1 == PTR_W'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      head_q  <= head_d;
      tail_q  <= tail_d;
      count_q <= count_d;
    end
  end

  // Data storage carries no reset; only entries being written are enabled.
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (we_lo[i])      slot_q[i] <= wr_data[7:0];
      else if (we_hi[i]) slot_q[i] <= wr_data[15:8];
    end
  end

  assign rd_data = {slot_q[head1], slot_q[head_q]};
  assign count   = count_q;

endmodule

// File: rtl/pq_pop_ctrl.sv
module pq_pop_ctrl #(
  parameter int CNT_W = 3
) (
  input  logic [1:0]       pop_cnt,
  input  logic [CNT_W-1:0] count,
  input  logic             flush,
  output logic [1:0]       rd_n,
  output logic             pop_stall
);

  logic [1:0] want;

  always_comb begin
    want      = pop_cnt[1] ? 2'd2 : {1'b0, pop_cnt[0]};
    pop_stall = CNT_W'(want) > count;
    rd_n      = (pop_stall || flush) ? 2'd0 : want;
  end

endmodule

// File: rtl/pq_bus_ctrl.sv
module pq_bus_ctrl
  import pq_pkg::*;
#(
  parameter bit                BUS16      = 1'b1,
  parameter int                ADDR_W     = 20,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
  parameter int                DEPTH      = 6,
  parameter int                CNT_W      = 3,
  localparam int               BUS_W      = BUS16 ? 16 : 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [ADDR_W-1:0] flush_addr,
  input  logic              opr_req,
  input  logic [ADDR_W-1:0] opr_addr,
  input  logic [CNT_W-1:0]  q_count,
  input  logic              mem_ready,
  input  logic [BUS_W-1:0]  mem_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_wide,
  output logic [1:0]        wr_n,
  output logic [15:0]       wr_data,
  output logic              opr_done,
  output logic [BUS_W-1:0]  opr_data
);

  bus_st_e           st_q, st_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              two_q, two_d;
  logic              stale_q, stale_d;
  logic              fetch_done, keep, ptr_en;
  logic [CNT_W-1:0]  free;

  always_comb begin
    fetch_done = (st_q == BUS_FETCH) && mem_ready;
    keep       = fetch_done && !stale_q && !flush;
    wr_n       = keep ? (two_q ? 2'd2 : 2'd1) : 2'd0;
    ptr_en     = flush || keep;
    ptr_d      = flush ? flush_addr : ptr_q + ADDR_W'(wr_n);

    // A fetch still on the bus at flush time is marked stale.
    if (fetch_done)                     stale_d = 1'b0;
    else if (flush && st_q == BUS_FETCH) stale_d = 1'b1;
    else                                 stale_d = stale_q;

    free   = flush ? CNT_W'(DEPTH) : CNT_W'(DEPTH) - q_count;
    st_d   = st_q;
    addr_d = addr_q;
    two_d  = two_q;
    unique case (st_q)
      BUS_IDLE: begin
        if (opr_req) begin
          st_d   = BUS_OPER;
          addr_d = opr_addr;
          two_d  = 1'b0;
        end else if (free != '0) begin
          st_d   = BUS_FETCH;
          addr_d = ptr_en ? ptr_d : ptr_q;
          two_d  = BUS16 && (free >= CNT_W'(2)) && !(ptr_en ? ptr_d[0] : ptr_q[0]);
        end
      end
      BUS_FETCH, BUS_OPER: begin
        if (mem_ready) st_d = BUS_IDLE;
      end
      default: st_d = BUS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= BUS_IDLE;
      ptr_q   <= RESET_ADDR;
      addr_q  <= '0;
      two_q   <= 1'b0;
      stale_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      stale_q <= stale_d;
      if (ptr_en) ptr_q <= ptr_d;
      if (st_q == BUS_IDLE) begin
        addr_q <= addr_d;
        two_q  <= two_d;
      end
    end
  end

  generate
    if (BUS16) begin : g_wide_lane
      always_comb begin
        if (two_q)          wr_data = mem_rdata;
        else if (addr_q[0]) wr_data = {8'h00, mem_rdata[15:8]};
        else                wr_data = {8'h00, mem_rdata[7:0]};
      end
    end else begin : g_narrow_lane
      assign wr_data = {8'h00, mem_rdata};
    end
  endgenerate

  assign mem_req  = (st_q != BUS_IDLE);
  assign mem_addr = addr_q;
  assign mem_wide = (st_q == BUS_FETCH) && two_q;
  assign opr_done = (st_q == BUS_OPER) && mem_ready;
  assign opr_data = mem_rdata;

endmodule

// File: rtl/pq_prefetch_queue.sv
module pq_prefetch_queue #(
  parameter bit                BUS16      = 1'b1,
  parameter int                ADDR_W     = 20,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
  localparam int               DEPTH      = pq_pkg::depth_for(BUS16),
  localparam int               CNT_W      = $clog2(DEPTH + 1),
  localparam int               BUS_W      = BUS16 ? 16 : 8
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_wide,
  input  logic [BUS_W-1:0]  mem_rdata,
  input  logic              mem_ready,
  input  logic [1:0]        pop_cnt,
  output logic [15:0]       pop_data,
  output logic              pop_stall,
  output logic [CNT_W-1:0]  q_level,
  input  logic              flush,
  input  logic [ADDR_W-1:0] flush_addr,
  input  logic              opr_req,
  input  logic [ADDR_W-1:0] opr_addr,
  output logic              opr_done,
  output logic [BUS_W-1:0]  opr_data
);

  logic [1:0]       wr_n, rd_n;
  logic [15:0]      wr_data;
  logic [CNT_W-1:0] count;

  pq_pop_ctrl #(.CNT_W(CNT_W)) u_pop (
    .pop_cnt   (pop_cnt),
    .count     (count),
    .flush     (flush),
    .rd_n      (rd_n),
    .pop_stall (pop_stall)
  );

  pq_bus_ctrl #(
    .BUS16      (BUS16),
    .ADDR_W     (ADDR_W),
    .RESET_ADDR (RESET_ADDR),
    .DEPTH      (DEPTH),
    .CNT_W      (CNT_W)
  ) u_bus (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .flush_addr (flush_addr),
    .opr_req    (opr_req),
    .opr_addr   (opr_addr),
    .q_count    (count),
    .mem_ready  (mem_ready),
    .mem_rdata  (mem_rdata),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_wide   (mem_wide),
    .wr_n       (wr_n),
    .wr_data    (wr_data),
    .opr_done   (opr_done),
    .opr_data   (opr_data)
  );

  pq_byte_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (flush),
    .wr_n    (wr_n),
    .wr_data (wr_data),
    .rd_n    (rd_n),
    .rd_data (pop_data),
    .count   (count)
  );

  assign q_level = count;

endmodule

// File: rtl/pq_prefetch_queue_chk.sv
module pq_prefetch_queue_chk #(
  parameter int ADDR_W = 20,
  parameter int DEPTH  = 6,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_wide,
  input logic              flush,
  input logic              opr_req,
  input logic [ADDR_W-1:0] opr_addr,
  input logic              pop_stall,
  input logic [CNT_W-1:0]  q_level
);

  // R3
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_level <= CNT_W'(DEPTH));

  // R4
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (q_level == '0));

  // R5
  full_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req && q_level == CNT_W'(DEPTH) && !flush && !opr_req) |=> !mem_req);

  // R6
  opr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req && opr_req) |=> (mem_req && mem_addr == $past(opr_addr)));

  // R7
  stall_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_stall && !flush) |=> (q_level >= $past(q_level)));

  // R9
  wide_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_wide) |-> !mem_addr[0]);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

endmodule

bind pq_prefetch_queue pq_prefetch_queue_chk #(
  .ADDR_W (ADDR_W),
  .DEPTH  (DEPTH),
  .CNT_W  (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .mem_wide  (mem_wide),
  .flush     (flush),
  .opr_req   (opr_req),
  .opr_addr  (opr_addr),
  .pop_stall (pop_stall),
  .q_level   (q_level)
);

// File: tb/tb_pq_prefetch_queue.sv
module tb_pq_prefetch_queue;

  localparam int          CLK_P = 10;
  localparam int          WD    = 20000;
  localparam logic [19:0] RST_A = 20'h00100;
  localparam logic [19:0] OPR_A = 20'h0A3C4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ready_en;

  // 16-bit bus instance
  logic        mem_req, mem_wide, mem_ready;
  logic [19:0] mem_addr;
  logic [15:0] mem_rdata;
  logic [1:0]  pop_cnt;
  logic [15:0] pop_data;
  logic        pop_stall;
  logic [2:0]  q_level;
  logic        flush;
  logic [19:0] flush_addr;
  logic        opr_req;
  logic [19:0] opr_addr;
  logic        opr_done;
  logic [15:0] opr_data;

  // 8-bit bus instance
  logic        n_req, n_wide, n_ready;
  logic [19:0] n_addr;
  logic [7:0]  n_rdata;
  logic [1:0]  n_pop;
  logic [15:0] n_data;
  logic        n_stall;
  logic [2:0]  n_level;
  logic        n_done;
  logic [7:0]  n_odata;

  int          total = 0;
  int          fails = 0;
  int          cyc   = 0;
  logic [19:0] next_pop;

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] mb(input logic [19:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  assign mem_ready = mem_req & ready_en;
  assign mem_rdata = {mb(mem_addr | 20'h1), mb(mem_addr & ~20'h1)};
  assign n_ready   = n_req;
  assign n_rdata   = mb(n_addr);

  pq_prefetch_queue #(.BUS16(1'b1), .ADDR_W(20), .RESET_ADDR(RST_A)) dut (
    .clk(clk), .rst_n(rst_n),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_wide(mem_wide),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .pop_cnt(pop_cnt), .pop_data(pop_data), .pop_stall(pop_stall), .q_level(q_level),
    .flush(flush), .flush_addr(flush_addr),
    .opr_req(opr_req), .opr_addr(opr_addr), .opr_done(opr_done), .opr_data(opr_data)
  );

  pq_prefetch_queue #(.BUS16(1'b0), .ADDR_W(20), .RESET_ADDR(RST_A)) dut_n (
    .clk(clk), .rst_n(rst_n),
    .mem_req(n_req), .mem_addr(n_addr), .mem_wide(n_wide),
    .mem_rdata(n_rdata), .mem_ready(n_ready),
    .pop_cnt(n_pop), .pop_data(n_data), .pop_stall(n_stall), .q_level(n_level),
    .flush(1'b0), .flush_addr(20'h0),
    .opr_req(1'b0), .opr_addr(20'h0), .opr_done(n_done), .opr_data(n_odata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WD);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  // Pops n bytes with code 1, 2 or 3 and checks them against the stream.
  task automatic pop_run(input int n, input int code, input string req);
    int sz;
    int got;
    sz  = (code >= 2) ? 2 : 1;
    got = 0;
    for (int g = 0; g < 1000 && got < n; g++) begin
      @(negedge clk);
      pop_cnt = 2'(code);
      #1;
      if (!pop_stall) begin
        chk(pop_data[7:0] == mb(next_pop), req, pop_data[7:0], mb(next_pop));
        if (sz == 2)
          chk(pop_data[15:8] == mb(next_pop + 20'h1), req, pop_data[15:8], mb(next_pop + 20'h1));
        next_pop = next_pop + 20'(sz);
        got      = got + sz;
      end
    end
    @(negedge clk);
    pop_cnt = 2'd0;
    chk(got >= n, req, got, n);
  endtask

  task automatic wait_req(output logic [19:0] a);
    for (int k = 0; k < 8 && !mem_req; k++) @(negedge clk);
    a = mem_addr;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    pop_cnt = 2'd1;
    #1;
    chk(q_level == 3'd0, "R1", q_level, 0);
    chk(mem_req == 1'b0, "R1", mem_req, 0);
    chk(pop_stall == 1'b1, "R7", pop_stall, 1);
    pop_cnt = 2'd0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(q_level == 3'd0 && mem_req == 1'b0, "R1", {q_level, mem_req}, 0);
    @(negedge clk);
    chk(mem_req && mem_addr == RST_A, "R1", mem_addr, RST_A);
    chk(mem_wide == 1'b1, "R9", mem_wide, 1);
  endtask

  task automatic t_fill_full;
    logic [19:0] a;
    for (int k = 0; k < 40 && q_level != 3'd6; k++) @(negedge clk);
    chk(q_level == 3'd6, "R3", q_level, 6);
    repeat (3) @(negedge clk);
    chk(mem_req == 1'b0, "R5", mem_req, 0);
    chk(q_level == 3'd6, "R5", q_level, 6);
    pop_run(1, 1, "R2");
    wait_req(a);
    chk(mem_req && a == RST_A + 20'h6, "R5", a, RST_A + 20'h6);
    chk(mem_wide == 1'b0, "R9", mem_wide, 0);
  endtask

  task automatic t_stream;
    pop_run(20, 2, "R2");
    pop_run(9, 1, "R2");
  endtask

  task automatic t_flush_inflight;
    logic [19:0] f;
    logic [19:0] a;
    @(negedge clk);
    ready_en = 1'b0;
    pop_run(2, 1, "R2");
    wait_req(f);
    chk(mem_req == 1'b1, "R8", mem_req, 1);
    @(negedge clk);
    flush      = 1'b1;
    flush_addr = 20'h00201;
    @(negedge clk);
    flush = 1'b0;
    #1;
    chk(q_level == 3'd0, "R4", q_level, 0);
    chk(mem_req && mem_addr == f, "R10", mem_addr, f);
    pop_cnt = 2'd1;
    #1;
    chk(pop_stall == 1'b1, "R7", pop_stall, 1);
    @(negedge clk);
    chk(q_level == 3'd0, "R7", q_level, 0);
    pop_cnt  = 2'd0;
    ready_en = 1'b1;
    a = 20'h0;
    for (int k = 0; k < 8 && !(mem_req && mem_addr == 20'h00201); k++) @(negedge clk);
    a = mem_addr;
    chk(mem_req && a == 20'h00201, "R4", a, 20'h00201);
    chk(mem_wide == 1'b0, "R9", mem_wide, 0);
    next_pop = 20'h00201;
    pop_run(10, 1, "R8");
  endtask

  task automatic t_operand;
    logic [19:0] f;
    bit          seen;
    @(negedge clk);
    ready_en = 1'b0;
    pop_run(2, 2, "R2");
    wait_req(f);
    opr_req  = 1'b1;
    opr_addr = OPR_A;
    repeat (3) @(negedge clk);
    chk(mem_req && mem_addr == f, "R10", mem_addr, f);
    ready_en = 1'b1;
    seen = 1'b0;
    for (int k = 0; k < 8 && !seen; k++) begin
      @(negedge clk);
      if (opr_done) begin
        seen = 1'b1;
        chk(mem_addr == OPR_A, "R6", mem_addr, OPR_A);
        chk(opr_data == {mb(OPR_A | 20'h1), mb(OPR_A & ~20'h1)}, "R6",
            opr_data, {mb(OPR_A | 20'h1), mb(OPR_A & ~20'h1)});
        opr_req = 1'b0;
      end
    end
    chk(seen, "R6", seen, 1);
    pop_run(12, 2, "R6");
  endtask

  task automatic t_pop_three;
    pop_run(6, 3, "R11");
  endtask

  task automatic t_narrow;
    logic [19:0] e;
    chk(n_level == 3'd4, "R3", n_level, 4);
    chk(n_req == 1'b0, "R5", n_req, 0);
    e = RST_A;
    for (int g = 0; g < 200 && e < RST_A + 20'h8; g++) begin
      @(negedge clk);
      n_pop = 2'd1;
      #1;
      if (n_req) chk(n_wide == 1'b0, "R9", n_wide, 0);
      if (!n_stall) begin
        chk(n_data[7:0] == mb(e), "R2", n_data[7:0], mb(e));
        e = e + 20'h1;
      end
    end
    @(negedge clk);
    n_pop = 2'd0;
    chk(e == RST_A + 20'h8, "R2", e, RST_A + 20'h8);
  endtask

  initial begin
    rst_n      = 1'b0;
    ready_en   = 1'b1;
    pop_cnt    = 2'd0;
    n_pop      = 2'd0;
    flush      = 1'b0;
    flush_addr = 20'h0;
    opr_req    = 1'b0;
    opr_addr   = 20'h0;
    next_pop   = RST_A;
    t_reset();
    t_fill_full();
    t_stream();
    t_flush_inflight();
    t_operand();
    t_pop_three();
    t_narrow();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule